// File: doc/BRIEF.md
# Interval Timer Alarm Generator

This block raises a periodic or one-time alarm on a slow timebase that sits beside a real-time clock. It receives a 128 Hz tick from the clock's prescaler and, from it, makes four candidate timebases by cascaded dividers: every tick, once a second, once a minute and once an hour. One of them, picked by a two-bit source select, advances an event counter. When a selected pulse arrives and finds the counter equal to the programmed interval, the block fires an alarm. The alarm sets a sticky flag and emits a one-cycle interrupt request.

The control inputs are level signals held by a configuration register elsewhere in the chip. They are not used directly. A shadow copy samples them on each 128 Hz tick, so a change takes effect at the next tick. After an alarm, a mode bit decides what happens. In repeating operation the counter clears and keeps counting. In single-shot operation it is held at zero until the enable is dropped.

Inside, a three-state controller sequences the counter. The states are OFF, RUN and HOLD.
- Any state moves to OFF whenever the sampled enable is low.
- OFF moves to RUN once enabled.
- RUN stays in RUN on a repeating match.
- RUN moves to HOLD on a single-shot match.
- HOLD stays in HOLD until the enable falls.

Top module: `interval_alarm`

## Requirements
- R1: While the sampled enable is low, no alarm fires, the event counter and all dividers are held at zero, and a single-shot hold is released.
- R2: Source select encoding: 0 = every 128 Hz tick, 1 = every TICKS_PER_SEC ticks (one second), 2 = every SEC_PER_MIN seconds (one minute), 3 = every MIN_PER_HOUR minutes (one hour), with the dividers starting from zero at the tick that enables the block.
- R3: A selected pulse that finds the counter equal to the interval fires an alarm; otherwise it increments the counter, so interval N fires on the (N+1)th pulse after enable and interval 0 fires on the first pulse.
- R4: An alarm sets the flag, which stays set until flag_clr_i is high on a clock edge with no alarm; an alarm in the same cycle as a clear leaves the flag set.
- R5: irq_o is high for exactly one cycle, the same cycle in which the flag is set by the alarm, one clock after the tick that caused it.
- R6: With oneshot_i = 0, the counter clears on an alarm and continues, so alarms repeat every N+1 pulses.
- R7: With oneshot_i = 1, the counter is held at zero after the alarm and no further alarm fires while the block stays enabled.
- R8: All control inputs are sampled only on clock edges where tick_i is high; the tick that samples a change is still processed under the previous settings.
- R9: Disabling and re-enabling restarts the count from zero, discarding any partial count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 128 Hz tick strobe |
| en_i | input | 1 | Timer enable |
| src_sel_i | input | 2 | Timebase select (0 tick, 1 second, 2 minute, 3 hour) |
| oneshot_i | input | 1 | 1 = hold after alarm, 0 = repeat |
| interval_i | input | CNT_W | Alarm interval value |
| flag_clr_i | input | 1 | Clears the alarm flag |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | One-cycle interrupt request on each alarm |

## Verification
The hardest situation to reach is a tick that is both the sampling edge for new settings and a counted pulse under the old ones.
- The bench changes the interval or drops the enable between ticks, so the next tick lands mid-count.
- It then checks that this tick's alarm decision used the previous value.
- It checks that the following alarms follow the new value.

The slow timebases are reached by shrinking the divider parameters. A one-hour source then completes in a few dozen ticks.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } itmr_state_e;

    typedef enum logic [1:0] {
        SRC_TICK = 2'd0,
        SRC_SEC  = 2'd1,
        SRC_MIN  = 2'd2,
        SRC_HOUR = 2'd3
    } itmr_src_e;

    typedef struct packed {
        logic      en;
        itmr_src_e src;
        logic      oneshot;
    } itmr_cfg_t;

    localparam int NUM_STAGES = 3;

endpackage

// File: rtl/itmr_cfg_sync.sv
module itmr_cfg_sync
    import itmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [1:0]       src_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] ival_i,
    output itmr_cfg_t        cfg_o,
    output logic [CNT_W-1:0] ival_o
);

    // Shadow copy refreshed only on the slow tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o  <= '{en: 1'b0, src: SRC_TICK, oneshot: 1'b0};
            ival_o <= '0;
        end else if (tick_i) begin
            cfg_o.en      <= en_i;
            cfg_o.src     <= itmr_src_e'(src_i);
            cfg_o.oneshot <= oneshot_i;
            ival_o        <= ival_i;
        end
    end

endmodule

// File: rtl/itmr_timebase.sv
module itmr_timebase
    import itmr_pkg::*;
#(
    parameter int TICKS_PER_SEC = 128,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_HOUR  = 60
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      run_i,
    input  itmr_src_e src_i,
    output logic      pulse_o
);

    localparam int LIM [NUM_STAGES] = '{TICKS_PER_SEC, SEC_PER_MIN, MIN_PER_HOUR};
    localparam int MAX_AB = (TICKS_PER_SEC > SEC_PER_MIN) ? TICKS_PER_SEC : SEC_PER_MIN;
    localparam int MAX_L  = (MAX_AB > MIN_PER_HOUR) ? MAX_AB : MIN_PER_HOUR;
    localparam int DW     = (MAX_L > 2) ? $clog2(MAX_L) : 1;

    logic [NUM_STAGES:0] carry;

    assign carry[0] = tick_i & run_i;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        logic [DW-1:0] cnt;
        logic          wrap;

        assign wrap         = (cnt == DW'(LIM[g] - 1));
        assign carry[g + 1] = carry[g] & wrap;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (!run_i) begin
                cnt <= '0;
            end else if (carry[g]) begin
                cnt <= wrap ? '0 : cnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (src_i)
            SRC_TICK: pulse_o = carry[0];
            SRC_SEC:  pulse_o = carry[1];
            SRC_MIN:  pulse_o = carry[2];
            SRC_HOUR: pulse_o = carry[3];
        endcase
    end

endmodule

// File: rtl/itmr_fsm.sv
module itmr_fsm
    import itmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] ival_i,
    input  logic             pulse_i,
    output logic             evt_o,
    output itmr_state_e      state_o
);

    itmr_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        evt_o   = 1'b0;
        if (!en_i) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF, ST_RUN: begin
                    state_d = ST_RUN;
                    if (pulse_i) begin
                        if (cnt_q == ival_i) begin
                            evt_o   = 1'b1;
                            cnt_d   = '0;
                            state_d = oneshot_i ? ST_HOLD : ST_RUN;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    cnt_d = '0;
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/itmr_flag.sv
module itmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic flag_o,
    output logic irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            irq_o <= evt_i;
            if (evt_i) begin
                flag_o <= 1'b1;
            end else if (clr_i) begin
                flag_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/interval_alarm.sv
module interval_alarm
    import itmr_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int TICKS_PER_SEC = 128,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_HOUR  = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [1:0]       src_sel_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             flag_clr_i,
    output logic             alarm_flag_o,
    output logic             irq_o
);

    itmr_cfg_t        act_cfg;
    logic [CNT_W-1:0] act_ival;
    logic             sel_pulse;
    logic             alarm_evt;
    itmr_state_e      fsm_state;

    itmr_cfg_sync #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .en_i      (en_i),
        .src_i     (src_sel_i),
        .oneshot_i (oneshot_i),
        .ival_i    (interval_i),
        .cfg_o     (act_cfg),
        .ival_o    (act_ival)
    );

    itmr_timebase #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SEC_PER_MIN   (SEC_PER_MIN),
        .MIN_PER_HOUR  (MIN_PER_HOUR)
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .run_i   (act_cfg.en),
        .src_i   (act_cfg.src),
        .pulse_o (sel_pulse)
    );

    itmr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (act_cfg.en),
        .oneshot_i (act_cfg.oneshot),
        .ival_i    (act_ival),
        .pulse_i   (sel_pulse),
        .evt_o     (alarm_evt),
        .state_o   (fsm_state)
    );

    itmr_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (alarm_evt),
        .clr_i  (flag_clr_i),
        .flag_o (alarm_flag_o),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/interval_alarm_chk.sv
module interval_alarm_chk
    import itmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             flag_clr_i,
    input logic             act_en,
    input logic [CNT_W-1:0] act_ival,
    input logic             sel_pulse,
    input itmr_state_e      fsm_state,
    input logic             alarm_flag_o,
    input logic             irq_o
);

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> !irq_o);

    a_r3_irq_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(sel_pulse));

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag_o && !flag_clr_i) |=> alarm_flag_o);

    a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !sel_pulse) |=> !alarm_flag_o);

    a_r5_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> alarm_flag_o);

    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HOLD && act_en) |=> !irq_o);

    a_r8_cfg_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(act_ival) && $stable(act_en)));

endmodule

bind interval_alarm interval_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .flag_clr_i   (flag_clr_i),
    .act_en       (act_cfg.en),
    .act_ival     (act_ival),
    .sel_pulse    (sel_pulse),
    .fsm_state    (fsm_state),
    .alarm_flag_o (alarm_flag_o),
    .irq_o        (irq_o)
);

// File: tb/sim_interval_alarm.sv
`timescale 1ns/1ps
module sim_interval_alarm;

    localparam int CNT_W = 8;
    localparam int TPS   = 4;
    localparam int SPM   = 3;
    localparam int MPH   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             en_i = 1'b0;
    logic [1:0]       src_sel_i = 2'd0;
    logic             oneshot_i = 1'b0;
    logic [CNT_W-1:0] interval_i = '0;
    logic             flag_clr_i = 1'b0;
    logic             alarm_flag_o;
    logic             irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    interval_alarm #(
        .CNT_W(CNT_W), .TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM), .MIN_PER_HOUR(MPH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(en_i),
        .src_sel_i(src_sel_i), .oneshot_i(oneshot_i), .interval_i(interval_i),
        .flag_clr_i(flag_clr_i), .alarm_flag_o(alarm_flag_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One tick strobe; returns at the negedge after the capturing edge
    task automatic do_tick();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr_i = 1'b1;
        @(negedge clk) flag_clr_i = 1'b0;
    endtask

    task automatic shutdown();
        idle(2);
        en_i = 1'b0;
        do_tick();
        idle(2);
        clear_flag();
    endtask

    task automatic start(input int src, input bit one, input int ival);
        src_sel_i  = 2'(src);
        oneshot_i  = one;
        interval_i = CNT_W'(ival);
        en_i       = 1'b1;
        do_tick();
        idle(2);
    endtask

    // Ticks 1..n; alarm expected at tick 'first' and every 'period' after (0 = once)
    task automatic ticks_expect(input int n, input int period, input int first, input string req);
        for (int i = 1; i <= n; i++) begin
            bit exp;
            exp = (i == first) || (period > 0 && i > first && ((i - first) % period) == 0);
            do_tick();
            check({req, " irq"}, int'(irq_o), int'(exp));
            check({req, " flag"}, int'(alarm_flag_o), int'(exp));
            if (alarm_flag_o) clear_flag();
            idle(2);
        end
    endtask

    task automatic t_reset();
        check("R5 reset irq", int'(irq_o), 0);
        check("R4 reset flag", int'(alarm_flag_o), 0);
        do_tick();
        idle(3);
        check("R1 disabled no alarm", int'(alarm_flag_o), 0);
    endtask

    task automatic t_repeat();
        shutdown();
        start(0, 1'b0, 3);
        ticks_expect(10, 4, 4, "R6");
    endtask

    task automatic t_zero();
        shutdown();
        start(0, 1'b0, 0);
        ticks_expect(3, 1, 1, "R3");
    endtask

    task automatic t_oneshot();
        shutdown();
        start(0, 1'b1, 2);
        ticks_expect(9, 0, 3, "R7");
        shutdown();
        start(0, 1'b1, 2);
        ticks_expect(4, 0, 3, "R1");
    endtask

    task automatic t_sources();
        shutdown();
        start(1, 1'b0, 1);
        ticks_expect(17, 8, 8, "R2 sec");
        shutdown();
        start(2, 1'b1, 0);
        ticks_expect(13, 0, 12, "R2 min");
        shutdown();
        start(3, 1'b1, 0);
        ticks_expect(25, 0, 24, "R2 hour");
    endtask

    task automatic t_latency();
        shutdown();
        src_sel_i  = 2'd0;
        oneshot_i  = 1'b0;
        interval_i = '0;
        en_i       = 1'b1;
        idle(20);
        check("R8 no tick no effect", int'(alarm_flag_o), 0);
        do_tick();
        idle(2);
        check("R8 load tick not counted", int'(alarm_flag_o), 0);
        ticks_expect(1, 1, 1, "R8 first");
        interval_i = CNT_W'(2);
        ticks_expect(4, 3, 1, "R8 old value on capture tick");
    endtask

    task automatic t_disable();
        shutdown();
        start(0, 1'b0, 3);
        ticks_expect(2, 0, 100, "R9 partial");
        en_i = 1'b0;
        do_tick();
        idle(2);
        check("R9 disabling tick still counts", int'(alarm_flag_o), 0);
        en_i = 1'b1;
        do_tick();
        idle(2);
        ticks_expect(4, 4, 4, "R9 restart");
    endtask

    task automatic t_clr_race();
        shutdown();
        start(0, 1'b0, 0);
        @(negedge clk) begin tick_i = 1'b1; flag_clr_i = 1'b1; end
        @(negedge clk) begin tick_i = 1'b0; flag_clr_i = 1'b0; end
        check("R4 set wins over clear", int'(alarm_flag_o), 1);
        check("R5 irq on race", int'(irq_o), 1);
        idle(1);
        check("R5 irq one cycle", int'(irq_o), 0);
        idle(10);
        check("R4 sticky", int'(alarm_flag_o), 1);
        clear_flag();
        check("R4 clear", int'(alarm_flag_o), 0);
        shutdown();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_repeat();
        t_zero();
        t_oneshot();
        t_sources();
        t_latency();
        t_disable();
        t_clr_race();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule